// File: doc/BRIEF.md
# Dual-Port Flash Read Controller with Wait-State Select

This block stands between a system read bus and a flash array that offers two independent synchronous read ports. It accepts one word read at a time over a valid/ready handshake, drives the array, and returns the word on a single-cycle response strobe. A one-bit setting, written over a separate configuration port, selects zero or one wait state. No longer setting exists.

With zero wait states only array port A is used, and the response arrives one cycle after acceptance. With one wait state a read that misses runs both ports in the same cycle: port A fetches the requested word and port B fetches the word after it. The word from port B goes into a one-entry buffer tagged with its address. A later request to exactly that address is answered one cycle after acceptance and touches neither port. A user page beyond the main array is addressed through one extra address bit and is read with the same path and timing. The next-word fetch never crosses from the main array into the user page, and never runs past the last word of either region.

Top module: `flash_rd_ctrl`

## Requirements
- R1: After reset, rd_ready is 1, rsp_valid is 0, both port enables are 0, the wait-state setting is 0 and the next-word buffer is empty.
- R2: With the setting at 0, an accepted read asserts pa_en with pa_addr equal to the request address in the acceptance cycle, and returns the array word with rsp_valid high exactly one cycle after acceptance.
- R3: While the setting is 0 at acceptance, pb_en is never asserted for that read.
- R4: With the setting at 1, a read that misses the buffer asserts pa_en (requested address) and pb_en (next address) together in the cycle after acceptance, and returns data two cycles after acceptance.
- R5: With the setting at 1, a read whose address equals the valid buffer tag returns the buffered word one cycle after acceptance and enables no array port.
- R6: A configuration write that changes the setting empties the buffer, including one that falls in the cycle a fill would occur. A write of the unchanged value keeps the buffer.
- R7: A miss on the last main-array word (index P*W-1) leaves pb_en low and empties the buffer, so no fetch crosses into the user page.
- R8: Address bit AW-1 set selects the user page of W words, offset in the low log2(W) bits. It is read with the same timing as the main array. Its next-word fetch stops at offset W-1.
- R9: rd_ready is 0 from acceptance until the response cycle has ended, so at most one read is outstanding.
- R10: The setting in force at acceptance governs the read. A change written in the acceptance cycle applies to later reads. pb_en stays low while the setting is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ws | input | 1 | Wait-state setting written (0 or 1) |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Controller can accept a request |
| rd_addr | input | AW | Word address; top bit selects the user page |
| rsp_valid | output | 1 | Read data valid strobe |
| rsp_data | output | DW | Read data |
| pa_en | output | 1 | Array port A enable |
| pa_addr | output | AW | Array port A address |
| pa_rdata | input | DW | Array port A data, one cycle after enable |
| pb_en | output | 1 | Array port B enable |
| pb_addr | output | AW | Array port B address |
| pb_rdata | input | DW | Array port B data, one cycle after enable |

## Verification
The collision of interest is a configuration write that lands in the same cycle as a buffer fill or a request acceptance. The bench drives the setting change in the response cycle of a one-wait miss, which is also the fill edge, and checks that the next read uses the array. It also drives a same-value write at the same point and checks that the following sequential read still hits. A setting change issued together with an acceptance is judged by the latency and port-enable counts of that read and of the next one.

// File: rtl/fr_pkg.sv
package fr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_RESP_ARR,
        ST_RESP_BUF
    } fr_state_e;
endpackage

// File: rtl/fr_next_addr.sv
module fr_next_addr #(
    parameter int P  = 16,
    parameter int W  = 8,
    localparam int TOTAL = P * W,
    localparam int WA    = $clog2(TOTAL),
    localparam int OFFW  = $clog2(W),
    localparam int AW    = WA + 1
) (
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] nxt,
    output logic          ok
);
    localparam logic [WA-1:0]   LAST_MAIN = WA'(TOTAL - 1);
    localparam logic [OFFW-1:0] LAST_OFF  = OFFW'(W - 1);

    always_comb begin
        if (addr[AW-1]) begin
            ok  = (addr[OFFW-1:0] != LAST_OFF);
            nxt = {1'b1, {(WA-OFFW){1'b0}}, addr[OFFW-1:0] + OFFW'(1)};
        end else begin
            ok  = (addr[WA-1:0] < LAST_MAIN);
            nxt = {1'b0, addr[WA-1:0] + WA'(1)};
        end
    end
endmodule

// File: rtl/fr_nxt_buf.sv
module fr_nxt_buf #(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          fill,
    input  logic [AW-1:0] fill_tag,
    input  logic [DW-1:0] fill_data,
    input  logic [AW-1:0] look_addr,
    output logic          hit,
    output logic          valid,
    output logic [DW-1:0] data
);
    typedef struct packed {
        logic          vld;
        logic [AW-1:0] tag;
        logic [DW-1:0] dat;
    } buf_t;

    buf_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (clr) begin
            b_d.vld = 1'b0;
        end else if (fill) begin
            b_d.vld = 1'b1;
            b_d.tag = fill_tag;
            b_d.dat = fill_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign hit   = b_q.vld && (b_q.tag == look_addr);
    assign valid = b_q.vld;
    assign data  = b_q.dat;
endmodule

// File: rtl/flash_rd_ctrl.sv
module flash_rd_ctrl #(
    parameter int P  = 16,
    parameter int W  = 8,
    parameter int DW = 32,
    localparam int WA = $clog2(P * W),
    localparam int AW = WA + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic          cfg_ws,
    input  logic          rd_valid,
    output logic          rd_ready,
    input  logic [AW-1:0] rd_addr,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          pa_en,
    output logic [AW-1:0] pa_addr,
    input  logic [DW-1:0] pa_rdata,
    output logic          pb_en,
    output logic [AW-1:0] pb_addr,
    input  logic [DW-1:0] pb_rdata
);
    import fr_pkg::*;

    typedef struct packed {
        fr_state_e     st;
        logic          ws;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          pend;
    } regs_t;

    regs_t r_d, r_q;

    logic          ws_chg;
    logic [AW-1:0] nxt_addr;
    logic          nxt_ok;
    logic          buf_clr, buf_fill, buf_hit, buf_valid, clr_fetch;
    logic [DW-1:0] buf_data;

    fr_next_addr #(.P(P), .W(W)) i_nxt (
        .addr (r_q.addr),
        .nxt  (nxt_addr),
        .ok   (nxt_ok)
    );

    fr_nxt_buf #(.AW(AW), .DW(DW)) i_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (buf_clr),
        .fill      (buf_fill),
        .fill_tag  (nxt_addr),
        .fill_data (pb_rdata),
        .look_addr (rd_addr),
        .hit       (buf_hit),
        .valid     (buf_valid),
        .data      (buf_data)
    );

    assign ws_chg  = cfg_we && (cfg_ws != r_q.ws);
    assign buf_clr = ws_chg || clr_fetch;

    always_comb begin
        r_d       = r_q;
        rd_ready  = (r_q.st == ST_IDLE);
        rsp_valid = 1'b0;
        rsp_data  = '0;
        pa_en     = 1'b0;
        pa_addr   = '0;
        pb_en     = 1'b0;
        pb_addr   = '0;
        buf_fill  = 1'b0;
        clr_fetch = 1'b0;
        if (cfg_we) r_d.ws = cfg_ws;
        unique case (r_q.st)
            ST_IDLE: begin
                if (rd_valid) begin
                    r_d.addr = rd_addr;
                    if (!r_q.ws) begin
                        pa_en   = 1'b1;
                        pa_addr = rd_addr;
                        r_d.st  = ST_RESP_ARR;
                    end else if (buf_hit) begin
                        r_d.data = buf_data;
                        r_d.st   = ST_RESP_BUF;
                    end else begin
                        r_d.st = ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                pa_en     = 1'b1;
                pa_addr   = r_q.addr;
                pb_en     = nxt_ok && r_q.ws;
                pb_addr   = nxt_addr;
                clr_fetch = !pb_en;
                r_d.pend  = pb_en && !ws_chg;
                r_d.st    = ST_RESP_ARR;
            end
            ST_RESP_ARR: begin
                rsp_valid = 1'b1;
                rsp_data  = pa_rdata;
                buf_fill  = r_q.pend;
                r_d.pend  = 1'b0;
                r_d.st    = ST_IDLE;
            end
            ST_RESP_BUF: begin
                rsp_valid = 1'b1;
                rsp_data  = r_q.data;
                r_d.st    = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    // R9: a response never overlaps with readiness for a new request
    p_single_outstanding_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !rd_ready);

    // R2: zero-wait read answers in the next cycle
    p_lat_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ready && !r_q.ws) |=> rsp_valid);

    // R4: a one-wait miss answers two cycles after acceptance
    p_lat_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ready && r_q.ws && !buf_hit) |=> !rsp_valid ##1 rsp_valid);

    // R4: port B only runs alongside port A, on another word
    p_port_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pb_en |-> (pa_en && pb_addr != pa_addr));

    // R5: a hit answers next cycle without any array access
    p_hit_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ready && r_q.ws && buf_hit) |=> (rsp_valid && !pa_en && !pb_en));

    // R6: a setting change leaves the buffer empty
    p_cfg_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_ws != r_q.ws) |=> !buf_valid);
endmodule

// File: tb/test_flash_rd_ctrl.sv
`timescale 1ns/1ps
module test_flash_rd_ctrl;
    localparam int P  = 16;
    localparam int W  = 8;
    localparam int DW = 32;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0, cfg_ws = 1'b0;
    logic          rd_valid = 1'b0;
    logic          rd_ready;
    logic [AW-1:0] rd_addr = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_data;
    logic          pa_en, pb_en;
    logic [AW-1:0] pa_addr, pb_addr;
    logic [DW-1:0] pa_rdata = '0, pb_rdata = '0;
    int            pa_cnt = 0, pb_cnt = 0;
    int            checks = 0, fails = 0;
    bit            done = 1'b0;

    always #4 clk = ~clk;

    flash_rd_ctrl #(.P(P), .W(W), .DW(DW)) i_flash_rd_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ws(cfg_ws),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .pa_en(pa_en), .pa_addr(pa_addr), .pa_rdata(pa_rdata),
        .pb_en(pb_en), .pb_addr(pb_addr), .pb_rdata(pb_rdata)
    );

    function automatic logic [DW-1:0] word_at(input logic [AW-1:0] a);
        return ({24'd0, a} * 32'h9E3779B1) ^ 32'h00C0FFEE;
    endfunction

    always @(posedge clk) begin
        if (pa_en) begin
            pa_rdata <= word_at(pa_addr);
            pa_cnt   <= pa_cnt + 1;
        end
        if (pb_en) begin
            pb_rdata <= word_at(pb_addr);
            pb_cnt   <= pb_cnt + 1;
        end
    end

    task automatic chk(input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    task automatic cfg(input logic v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ws = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // cfg_acc / cfg_rsp: -1 none, else value written in acceptance / response cycle
    task automatic rd(input logic [AW-1:0] a, input int lat_e, input int pa_e,
                      input int pb_e, input string rq,
                      input int cfg_acc = -1, input int cfg_rsp = -1);
        int pa0, pb0, lat;
        @(negedge clk);
        chk({rq, " ready"}, rd_ready, 1);
        rd_valid = 1'b1; rd_addr = a;
        pa0 = pa_cnt; pb0 = pb_cnt;
        if (cfg_acc >= 0) begin cfg_we = 1'b1; cfg_ws = cfg_acc[0]; end
        @(negedge clk);
        rd_valid = 1'b0; cfg_we = 1'b0;
        lat = 1;
        while (rsp_valid !== 1'b1 && lat < 8) begin
            chk("R9 busy", rd_ready, 0);
            @(negedge clk);
            lat++;
        end
        chk({rq, " latency"}, lat, lat_e);
        chk({rq, " data"}, rsp_data, word_at(a));
        chk("R9 no ready in rsp", rd_ready, 0);
        if (cfg_rsp >= 0) begin cfg_we = 1'b1; cfg_ws = cfg_rsp[0]; end
        @(posedge clk);
        #1;
        chk({rq, " pa count"}, pa_cnt - pa0, pa_e);
        chk({rq, " pb count (R3)"}, pb_cnt - pb0, pb_e);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        #800000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready", rd_ready, 1);
        chk("R1 rsp_valid", rsp_valid, 0);
        chk("R1 pa_en", pa_en, 0);
        chk("R1 pb_en", pb_en, 0);

        // zero wait states: every main and user word
        for (int i = 0; i < P * W; i++) rd(AW'(i), 1, 1, 0, "R2");
        for (int o = 0; o < W; o++) rd(8'h80 | AW'(o), 1, 1, 0, "R8 user 0ws");

        // one wait state: sequential sweep, misses and hits alternate
        cfg(1'b1);
        for (int i = 0; i < P * W; i++) begin
            if (i % 2 == 0) rd(AW'(i), 2, 1, 1, "R4 miss");
            else            rd(AW'(i), 1, 0, 0, "R5 hit");
        end
        for (int o = 0; o < W; o++) begin
            if (o % 2 == 0) rd(8'h80 | AW'(o), 2, 1, 1, "R8 user miss");
            else            rd(8'h80 | AW'(o), 1, 0, 0, "R8 user hit");
        end

        // user page end: no prefetch, buffer emptied
        rd(8'h83, 2, 1, 1, "R8 prime");
        rd(8'h87, 2, 1, 0, "R8 last offset");
        rd(8'h84, 2, 1, 1, "R8 buffer emptied");

        // main array end
        rd(8'd50, 2, 1, 1, "R7 prime");
        rd(8'd127, 2, 1, 0, "R7 last word");
        rd(8'd51, 2, 1, 1, "R7 buffer emptied");
        rd(8'd127, 2, 1, 0, "R7 last again");
        rd(8'h80, 2, 1, 1, "R7 no cross");

        // setting change empties buffer
        rd(8'd10, 2, 1, 1, "R6 prime");
        cfg(1'b0);
        cfg(1'b1);
        rd(8'd11, 2, 1, 1, "R6 after toggle");

        // same-value write in the fill cycle keeps buffer
        rd(8'd20, 2, 1, 1, "R6 fill same", -1, 1);
        rd(8'd21, 1, 0, 0, "R6 kept");

        // change written in the fill cycle
        rd(8'd40, 2, 1, 1, "R6 fill change", -1, 0);
        rd(8'd41, 1, 1, 0, "R6 zero mode");
        cfg(1'b1);
        rd(8'd41, 2, 1, 1, "R6 refetch");

        // change written in the acceptance cycle
        rd(8'd30, 2, 1, 0, "R10 accept change", 0);
        rd(8'd31, 1, 1, 0, "R10 new mode");
        rd(8'h85, 1, 1, 0, "R10 user 0ws");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule